// File: doc/BRIEF.md
# I2C Memory Read Target

This block is an I2C target that serves read accesses to an internal byte memory. A fast system clock oversamples the SCL and SDA lines through two-flop synchronisers. The block pulls SDA low through an open-drain style output enable and never drives the line high. One word-address counter is shared by every read mode. The master loads it with a write-direction phase that carries a two-byte word address.

The master has four ways to read. A random read sends the word address, then a repeated start and the device address with the read bit set; the target then returns data from that address. A set-current-address operation ends with a stop straight after the word address; this loads the counter and does nothing else. A current-address read returns data from wherever the counter points. In a sequential read, each master acknowledge fetches the byte at the next address, wrapping from the top of the array back to zero.

A side port lets a testbench preload the memory. After a stop the target is in standby and ignores the bus until it sees a start condition.

Top module: `i2c_rd_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe` = 0) and the address counter is zero, so the first current-address read returns the byte at address 0.
- R2: A device-address byte is the 7-bit address in bits 7..1 and the read/write bit in bit 0, with 1 meaning read. When the address matches `DEV_ADDR`, the target pulls SDA low during the ninth clock. On a mismatch it never drives SDA until the next start.
- R3: The target acknowledges each of the two word-address bytes. It joins them with the first byte as the most significant byte, then keeps the low log2(DEPTH) bits.
- R4: A random read works as follows: a write-direction phase carries the word address, then a repeated start and the device address with bit 0 set. The target then returns the byte at that word address.
- R5: A stop sent straight after the word address loads the counter and nothing else. The next current-address read returns the byte at the loaded address.
- R6: After a stop, clocked bus traffic without a start gets no acknowledge, and the target does not drive SDA.
- R7: During a read, each master acknowledge makes the target send the byte at the next address (n+1 after n).
- R8: On a master NACK, the target releases SDA and sends nothing more until a new start.
- R9: Past address DEPTH-1, the counter wraps to 0 and sequential reading continues.
- R10: After each byte sent, the counter holds the following address. A later current-address read therefore continues where the previous read stopped.
- R11: The target changes SDA only while SCL is low.
- R12: A pulse on `pre_we` writes `pre_data` to memory location `pre_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | log2(DEPTH) | Preload address |
| pre_data | input | 8 | Preload data byte |

## Verification
The assertions check on every cycle that SDA is released in standby, after an address mismatch and during the master's acknowledge slot. They also check that the output enable changes only while the synchronised SCL is low, and that each transmitted byte advances the counter by exactly one, modulo the array size. Only the bench's bus scenarios can show the data results: that random, current-address and sequential reads return the right bytes, that the address is masked, and that a stop-terminated address load changes the counter without a data access. The same holds for the wrap at the top of the array and for the counter carrying over from one read transaction to the next.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,   // standby, waits for start
    ST_DEV,    // receiving device address byte
    ST_DACK,   // acknowledging device address
    ST_AHI,    // receiving word address high byte
    ST_AHACK,  // acknowledging high byte
    ST_ALO,    // receiving word address low byte
    ST_ALACK,  // acknowledging low byte
    ST_WAIT,   // address loaded or read ended, waits for start/stop
    ST_TX,     // shifting a data byte out
    ST_MACK    // master acknowledge slot
  } rd_state_e;
endpackage

// File: rtl/i2c_rd_sync.sv
module i2c_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int W = STAGES + 1;

  logic [W-1:0] scl_p;
  logic [W-1:0] sda_p;

  // Synchroniser chain plus one history stage per line; reset to idle bus.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[W-2:0], scl_i};
      sda_p <= {sda_p[W-2:0], sda_i};
    end
  end

  assign scl_s     = scl_p[W-2];
  assign sda_s     = sda_p[W-2];
  assign scl_rise  =  scl_p[W-2] & ~scl_p[W-1];
  assign scl_fall  = ~scl_p[W-2] &  scl_p[W-1];
  // SDA moves while SCL stays high: falling is start, rising is stop.
  assign start_det = scl_p[W-2] & scl_p[W-1] &  sda_p[W-1] & ~sda_p[W-2];
  assign stop_det  = scl_p[W-2] & scl_p[W-1] & ~sda_p[W-1] &  sda_p[W-2];
endmodule

// File: rtl/i2c_rd_mem.sv
module i2c_rd_mem #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  // Single write port, registered read port: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_rd_engine.sv
module i2c_rd_engine
  import i2c_rd_pkg::*;
#(
  parameter int         AW       = 9,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] addr_q,
  output logic          sda_oe
);
  rd_state_e  state;
  logic [3:0] cnt;
  logic [7:0] sr;
  logic [7:0] hi_q;
  logic [7:0] tx_q;
  logic       rw_q;
  logic       ackd_q;
  logic       oe_q;
  logic       rx_state;

  assign rx_state = (state == ST_DEV) || (state == ST_AHI) || (state == ST_ALO);
  assign sda_oe   = oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sr     <= '0;
      hi_q   <= '0;
      tx_q   <= '0;
      rw_q   <= 1'b0;
      ackd_q <= 1'b0;
      oe_q   <= 1'b0;
      addr_q <= '0;
    end else if (start_det) begin
      state <= ST_DEV;
      cnt   <= '0;
      oe_q  <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
    end else begin
      if (scl_rise && rx_state) begin
        sr  <= {sr[6:0], sda_s};
        cnt <= cnt + 4'd1;
      end
      if (scl_rise && state == ST_MACK) ackd_q <= ~sda_s;
      if (scl_fall) begin
        case (state)
          ST_DEV: if (cnt == 4'd8) begin
            cnt <= '0;
            if (sr[7:1] == DEV_ADDR) begin
              oe_q  <= 1'b1;
              rw_q  <= sr[0];
              state <= ST_DACK;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_DACK: if (rw_q) begin
            tx_q  <= rd_data;
            oe_q  <= ~rd_data[7];
            cnt   <= 4'd1;
            state <= ST_TX;
          end else begin
            oe_q  <= 1'b0;
            state <= ST_AHI;
          end
          ST_AHI: if (cnt == 4'd8) begin
            cnt   <= '0;
            hi_q  <= sr;
            oe_q  <= 1'b1;
            state <= ST_AHACK;
          end
          ST_AHACK: begin
            oe_q  <= 1'b0;
            state <= ST_ALO;
          end
          ST_ALO: if (cnt == 4'd8) begin
            cnt    <= '0;
            addr_q <= AW'({hi_q, sr});
            oe_q   <= 1'b1;
            state  <= ST_ALACK;
          end
          ST_ALACK: begin
            oe_q  <= 1'b0;
            state <= ST_WAIT;
          end
          ST_TX: if (cnt == 4'd8) begin
            oe_q   <= 1'b0;
            addr_q <= addr_q + 1'b1;
            state  <= ST_MACK;
          end else begin
            oe_q <= ~tx_q[3'd7 - cnt[2:0]];
            cnt  <= cnt + 4'd1;
          end
          ST_MACK: if (ackd_q) begin
            tx_q  <= rd_data;
            oe_q  <= ~rd_data[7];
            cnt   <= 4'd1;
            state <= ST_TX;
          end else begin
            state <= ST_WAIT;
          end
          default: ;
        endcase
      end
    end
  end

  // R11: the SDA enable only moves while synchronised SCL is low.
  a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    (oe_q != $past(oe_q)) |-> !scl_s);

  // R6: standby never drives the line.
  a_r6_standby_released: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !oe_q);

  // R2: a device address byte that ends in standby left SDA released.
  a_r2_mismatch_no_ack: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_DEV && state == ST_IDLE) |-> !oe_q);

  // R8: the master acknowledge slot is never driven by the target.
  a_r8_mack_released: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MACK) |-> !oe_q);

  // R9, R10: leaving a sent byte moves the counter by exactly one, wrapping.
  a_r9_counter_step: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_TX && state == ST_MACK) |-> addr_q == AW'($past(addr_q) + 1'b1));
endmodule

// File: rtl/i2c_rd_target.sv
module i2c_rd_target #(
  parameter int         DEPTH    = 512,
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [7:0]    pre_data
);
  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0] addr_q;
  logic [7:0]    rd_data;

  i2c_rd_sync #(.STAGES(2)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rd_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (pre_we),
    .waddr (pre_addr),
    .wdata (pre_data),
    .raddr (addr_q),
    .rdata (rd_data)
  );

  i2c_rd_engine #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .addr_q    (addr_q),
    .sda_oe    (sda_oe)
  );
endmodule

// File: tb/i2c_rd_target_bench.sv
module i2c_rd_target_bench;
  localparam int         DEPTH = 512;
  localparam int         AW    = 9;
  localparam logic [6:0] DEV   = 7'h50;
  localparam int         HALF  = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic          m_scl_low, m_sda_low;
  logic          scl_line, sda_line;
  logic          sda_oe;
  logic          pre_we;
  logic [AW-1:0] pre_addr;
  logic [7:0]    pre_data;

  assign scl_line = ~m_scl_low;
  assign sda_line = ~(m_sda_low | sda_oe);

  i2c_rd_target #(.DEPTH(DEPTH), .DEV_ADDR(DEV)) u_i2c_rd_target (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_line),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe),
    .pre_we   (pre_we),
    .pre_addr (pre_addr),
    .pre_data (pre_data)
  );

  int checks = 0;
  int failures = 0;
  int hi_glitch = 0;
  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 5) % 256);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (HALF) @(negedge clk);
  endtask

  // Start from idle or from SCL low (repeated start).
  task automatic bstart();
    m_sda_low = 1'b0; hp();
    m_scl_low = 1'b0; hp();
    m_sda_low = 1'b1; hp();
    m_scl_low = 1'b1; hp();
  endtask

  task automatic bstop();
    m_sda_low = 1'b1; hp();
    m_scl_low = 1'b0; hp();
    m_sda_low = 1'b0; hp();
  endtask

  // One SCL pulse; SDA is sampled early in the high phase and watched until it ends.
  task automatic bit_cycle(input logic b, output logic s);
    m_sda_low = ~b; hp();
    m_scl_low = 1'b0;
    repeat (3) @(negedge clk);
    s = sda_line;
    repeat (HALF - 3) begin
      @(negedge clk);
      if (sda_line != s) hi_glitch++;
    end
    m_scl_low = 1'b1; hp();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bit_cycle(1'b1, s);
      d = {d[6:0], s};
    end
    bit_cycle(~give_ack, s);
  endtask

  // Driver: push expected bytes, hand the read bytes to the monitor.
  task automatic rd_body(int n, int base, string tag);
    logic ack;
    logic [7:0] d;
    wr_byte({DEV, 1'b1}, ack);
    chk(ack == 1'b1, "R2 read device address acknowledged", ack, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i < n - 1, d);
      exp_q.push_back(pat((base + i) % DEPTH));
      tag_q.push_back(tag);
      act_q.push_back(d);
    end
  endtask

  task automatic set_addr(logic [7:0] hi, logic [7:0] lo);
    logic ack;
    bstart();
    wr_byte({DEV, 1'b0}, ack);
    chk(ack == 1'b1, "R2 write device address acknowledged", ack, 1);
    wr_byte(hi, ack);
    chk(ack == 1'b1, "R3 high address byte acknowledged", ack, 1);
    wr_byte(lo, ack);
    chk(ack == 1'b1, "R3 low address byte acknowledged", ack, 1);
  endtask

  // Monitor: compare each produced byte with the head of the expected queue.
  initial begin
    logic [7:0] a, e;
    string t;
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        a = act_q.pop_front();
        if (exp_q.size() == 0) begin
          chk(1'b0, "scoreboard underflow", a, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(a == e, t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    rst = 1'b1; m_scl_low = 1'b0; m_sda_low = 1'b0;
    pre_we = 1'b0; pre_addr = '0; pre_data = '0;
    // R12: preload every location through the side port.
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      pre_we = 1'b1; pre_addr = AW'(i); pre_data = pat(i);
    end
    @(negedge clk); pre_we = 1'b0;
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 SDA released after reset", sda_oe, 0);

    // R1 counter at zero, R12 preloaded content
    bstart(); rd_body(1, 0, "R1 R12 first read from address 0"); bstop();

    // R2 mismatch: no acknowledge, nothing driven
    bstart();
    wr_byte({7'h51, 1'b1}, ack);
    chk(ack == 1'b0, "R2 mismatched address not acknowledged", ack, 0);
    rd_byte(1'b0, d);
    chk(d == 8'hFF, "R2 SDA stays released after mismatch", d, 8'hFF);
    bstop();

    // R4 random read
    set_addr(8'h01, 8'h23); bstart(); rd_body(1, 'h123, "R4 random read"); bstop();

    // R3 masking of the joined address
    set_addr(8'hFE, 8'h10); bstart(); rd_body(1, 'h010, "R3 address masked"); bstop();

    // R5 set-current-address then R6 standby traffic
    set_addr(8'h00, 8'h40); bstop();
    m_scl_low = 1'b1; hp();
    wr_byte({DEV, 1'b1}, ack);
    chk(ack == 1'b0, "R6 no acknowledge in standby", ack, 0);
    rd_byte(1'b0, d);
    chk(d == 8'hFF, "R6 SDA not driven in standby", d, 8'hFF);
    bstart(); rd_body(1, 'h040, "R5 read after set-current-address"); bstop();

    // R7 R9 sequential read across the top of the array
    set_addr(8'h01, 8'hFD); bstart(); rd_body(5, 'h1FD, "R7 R9 sequential with wrap");
    rd_byte(1'b0, d);
    chk(d == 8'hFF, "R8 no data after NACK", d, 8'hFF);
    bstop();

    // R10 counter continues from the last read
    bstart(); rd_body(2, 'h002, "R10 current read continues"); bstop();

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    chk(hi_glitch == 0, "R11 SDA stable while SCL high", hi_glitch, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule